// File: doc/BRIEF.md
# Serial DDS Frequency-Word Loader

This block sits on the host side of a direct digital synthesis chip and drives its four control pins: a device reset line, a serial bit clock, a serial data line and a frequency-update strobe. After system reset it runs a fixed start-up handshake that leaves the synthesizer in serial load mode. It then offers a valid/ready request port. Each request carries a precomputed 32-bit tuning word and a phase value. The block builds a 40-bit configuration frame from these, sends it one bit per bit-clock pulse, and then pulses the update strobe so that the chip moves the frame into its active register.

Every pulse width and gap is a parameter counted in system-clock cycles, so the pin timing can meet the chip's minimum widths at any system clock rate. A single down-counter times whichever state the controller is in. The frame sits in a right-shifting register, so the data pin always shows bit 0 of what is left of the frame.

The controller states are ST_RST_HI, ST_RST_LO, ST_BOOT_WCLK_HI, ST_BOOT_WCLK_LO, ST_BOOT_FQ_HI, ST_BOOT_FQ_LO, ST_IDLE, ST_SETUP, ST_WCLK_HI, ST_FQ_HI and ST_FQ_LO.

Transitions:
- System reset places the controller in ST_RST_HI.
- Each timed state moves on when its counter expires. The start-up chain runs ST_RST_HI → ST_RST_LO → ST_BOOT_WCLK_HI → ST_BOOT_WCLK_LO → ST_BOOT_FQ_HI → ST_BOOT_FQ_LO → ST_IDLE.
- ST_IDLE goes to ST_SETUP when a request is accepted.
- ST_SETUP goes to ST_WCLK_HI.
- ST_WCLK_HI returns to ST_SETUP (shifting the frame) while bits remain, and goes to ST_FQ_HI after the last bit.
- ST_FQ_HI goes to ST_FQ_LO, and ST_FQ_LO goes back to ST_IDLE.

Top module: `dds_serial_loader`

## Requirements
- R1: While rst_n is low, dds_reset is high and dds_wclk, dds_fqud, req_ready and busy are low. After rst_n rises, dds_reset stays high for exactly RST_HI_CYC cycles. Exactly one dds_wclk pulse and then exactly one dds_fqud pulse follow before req_ready first rises.
- R2: req_ready is high only when the block is idle after start-up. A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is high again once a transfer ends.
- R3: Each request yields exactly 40 rising edges of dds_wclk. The dds_data values seen at those edges, in order, are frame bits 0 to 39 (least significant first). Bits 0 to 31 hold req_tuning. Bits 35 to 39 hold req_phase[4:0]. The frame is captured at acceptance, so later changes on the request inputs do not affect it.
- R4: Frame bits 32 and 33 (control) and bit 34 (power-down) are always sent as 0. req_phase bits above bit 4 have no effect on the frame.
- R5: Each dds_wclk high pulse lasts exactly WCLK_HI_CYC cycles. After start-up, dds_wclk is low for at least WCLK_LO_CYC cycles before each rise. dds_data is unchanged for at least WCLK_LO_CYC cycles before each rise and for the whole high pulse.
- R6: After the 40th bit there is exactly one dds_fqud pulse of exactly FQ_HI_CYC cycles. dds_wclk and dds_fqud are never high together.
- R7: busy rises in the cycle after acceptance and stays high for exactly 40·(WCLK_LO_CYC+WCLK_HI_CYC)+FQ_HI_CYC+GAP_CYC cycles. During that time req_ready is low.
- R8: Once start-up is complete, dds_reset never rises again.
- R9: A request held valid during start-up is not taken until start-up completes; busy stays low throughout start-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_tuning | input | 32 | Precomputed frequency tuning word |
| req_phase | input | PH_IN_W (8) | Phase request; only bits 4:0 are used |
| busy | output | 1 | Transfer in progress |
| dds_reset | output | 1 | Synthesizer reset pin |
| dds_wclk | output | 1 | Serial bit clock pin |
| dds_data | output | 1 | Serial data pin |
| dds_fqud | output | 1 | Frequency update strobe pin |

## Verification
The hardest case to reach from the ports is a request that is already pending while the start-up handshake is still running. The bench raises req_valid with a known word before it releases rst_n. It then checks that busy stays low and that only the single start-up bit-clock and strobe pulses appear before req_ready rises, and that the held word is the first one sent. After acceptance the request inputs are inverted, to show that the frame was latched. Directed words that set every tuning bit and every phase bit (including the unused upper phase bits) are mixed with seeded random words.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    localparam int TW_W    = 32;
    localparam int CTRL_W  = 2;
    localparam int PD_W    = 1;
    localparam int PH_W    = 5;
    localparam int FRAME_W = TW_W + CTRL_W + PD_W + PH_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef enum logic [3:0] {
        ST_RST_HI,
        ST_RST_LO,
        ST_BOOT_WCLK_HI,
        ST_BOOT_WCLK_LO,
        ST_BOOT_FQ_HI,
        ST_BOOT_FQ_LO,
        ST_IDLE,
        ST_SETUP,
        ST_WCLK_HI,
        ST_FQ_HI,
        ST_FQ_LO
    } dsl_state_e;
endpackage

// File: rtl/dsl_timer.sv
module dsl_timer #(
    parameter int               CNT_W   = 4,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dsl_frame_shifter.sv
module dsl_frame_shifter
    import dsl_pkg::*;
#(
    parameter int PH_IN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [TW_W-1:0]    tuning,
    input  logic [PH_IN_W-1:0] phase,
    output logic               data_bit,
    output logic               last_bit
);
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;
    logic [PH_W-1:0]    phase_used;
    logic [FRAME_W-1:0] frame_new;

    assign phase_used = phase[PH_W-1:0];

    generate
        if (PH_IN_W > PH_W) begin : g_extra_phase
            logic unused_phase_hi;
            assign unused_phase_hi = ^phase[PH_IN_W-1:PH_W];
        end
    endgenerate

    // control and power-down positions are forced to zero
    assign frame_new = {phase_used, {PD_W{1'b0}}, {CTRL_W{1'b0}}, tuning};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            frame_q <= frame_new;
            idx_q   <= '0;
        end else if (shift) begin
            frame_q <= {1'b0, frame_q[FRAME_W-1:1]};
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign data_bit = frame_q[0];
    assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(FRAME_W - 1));

    // R3
    no_shift_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last_bit);

    // R4
    ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frame_q[TW_W +: (CTRL_W + PD_W)] == '0));
endmodule

// File: rtl/dsl_ctrl.sv
module dsl_ctrl
    import dsl_pkg::*;
#(
    parameter int RST_HI_CYC  = 3,
    parameter int WCLK_HI_CYC = 2,
    parameter int WCLK_LO_CYC = 2,
    parameter int FQ_HI_CYC   = 2,
    parameter int GAP_CYC     = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             tmr_expired,
    input  logic             shf_last,
    output logic             req_ready,
    output logic             busy,
    output logic             dds_reset,
    output logic             dds_wclk,
    output logic             dds_fqud,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             frame_load,
    output logic             frame_shift
);
    dsl_state_e state_q, state_d;

    function automatic logic [CNT_W-1:0] dur_of(input dsl_state_e s);
        int d;
        case (s)
            ST_RST_HI:       d = RST_HI_CYC;
            ST_BOOT_WCLK_HI: d = WCLK_HI_CYC;
            ST_WCLK_HI:      d = WCLK_HI_CYC;
            ST_SETUP:        d = WCLK_LO_CYC;
            ST_BOOT_FQ_HI:   d = FQ_HI_CYC;
            ST_FQ_HI:        d = FQ_HI_CYC;
            ST_IDLE:         d = 1;
            default:         d = GAP_CYC;
        endcase
        return CNT_W'(d - 1);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RST_HI;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_HI:       if (tmr_expired) state_d = ST_RST_LO;
            ST_RST_LO:       if (tmr_expired) state_d = ST_BOOT_WCLK_HI;
            ST_BOOT_WCLK_HI: if (tmr_expired) state_d = ST_BOOT_WCLK_LO;
            ST_BOOT_WCLK_LO: if (tmr_expired) state_d = ST_BOOT_FQ_HI;
            ST_BOOT_FQ_HI:   if (tmr_expired) state_d = ST_BOOT_FQ_LO;
            ST_BOOT_FQ_LO:   if (tmr_expired) state_d = ST_IDLE;
            ST_IDLE:         if (req_valid)   state_d = ST_SETUP;
            ST_SETUP:        if (tmr_expired) state_d = ST_WCLK_HI;
            ST_WCLK_HI: begin
                if (tmr_expired) state_d = shf_last ? ST_FQ_HI : ST_SETUP;
            end
            ST_FQ_HI:        if (tmr_expired) state_d = ST_FQ_LO;
            ST_FQ_LO:        if (tmr_expired) state_d = ST_IDLE;
            default:         state_d = ST_RST_HI;
        endcase
    end

    // outputs
    always_comb begin
        dds_reset   = (state_q == ST_RST_HI);
        dds_wclk    = (state_q == ST_BOOT_WCLK_HI) || (state_q == ST_WCLK_HI);
        dds_fqud    = (state_q == ST_BOOT_FQ_HI) || (state_q == ST_FQ_HI);
        req_ready   = (state_q == ST_IDLE);
        busy        = (state_q == ST_SETUP) || (state_q == ST_WCLK_HI) ||
                      (state_q == ST_FQ_HI) || (state_q == ST_FQ_LO);
        tmr_load    = (state_d != state_q);
        tmr_val     = dur_of(state_d);
        frame_load  = (state_q == ST_IDLE) && req_valid;
        frame_shift = (state_q == ST_WCLK_HI) && tmr_expired && !shf_last;
    end

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    // R6
    strobe_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dds_fqud) && busy) |-> shf_last);

    // R8
    no_reset_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || req_ready) |-> !dds_reset);
endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
    import dsl_pkg::*;
#(
    parameter int RST_HI_CYC  = 3,
    parameter int WCLK_HI_CYC = 2,
    parameter int WCLK_LO_CYC = 2,
    parameter int FQ_HI_CYC   = 2,
    parameter int GAP_CYC     = 2,
    parameter int PH_IN_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [TW_W-1:0]    req_tuning,
    input  logic [PH_IN_W-1:0] req_phase,
    output logic               busy,
    output logic               dds_reset,
    output logic               dds_wclk,
    output logic               dds_data,
    output logic               dds_fqud
);
    localparam int MAX_DUR = RST_HI_CYC + WCLK_HI_CYC + WCLK_LO_CYC + FQ_HI_CYC + GAP_CYC;
    localparam int CNT_W   = $clog2(MAX_DUR + 1);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_HI_CYC - 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             frame_load;
    logic             frame_shift;
    logic             shf_last;

    dsl_ctrl #(
        .RST_HI_CYC  (RST_HI_CYC),
        .WCLK_HI_CYC (WCLK_HI_CYC),
        .WCLK_LO_CYC (WCLK_LO_CYC),
        .FQ_HI_CYC   (FQ_HI_CYC),
        .GAP_CYC     (GAP_CYC),
        .CNT_W       (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .tmr_expired (tmr_expired),
        .shf_last    (shf_last),
        .req_ready   (req_ready),
        .busy        (busy),
        .dds_reset   (dds_reset),
        .dds_wclk    (dds_wclk),
        .dds_fqud    (dds_fqud),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .frame_load  (frame_load),
        .frame_shift (frame_shift)
    );

    dsl_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_LOAD)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dsl_frame_shifter #(
        .PH_IN_W (PH_IN_W)
    ) shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_load),
        .shift    (frame_shift),
        .tuning   (req_tuning),
        .phase    (req_phase),
        .data_bit (dds_data),
        .last_bit (shf_last)
    );

    // R5
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dds_wclk) |-> $stable(dds_data));

    // R6
    pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dds_wclk && dds_fqud));
endmodule

// File: tb/dds_serial_loader_tb_top.sv
module dds_serial_loader_tb_top;
    localparam int RST_HI  = 3;
    localparam int W_HI    = 2;
    localparam int W_LO    = 2;
    localparam int FQ_HI   = 2;
    localparam int GAP     = 2;
    localparam int NBITS   = 40;
    localparam int BUSY_CYC = NBITS * (W_LO + W_HI) + FQ_HI + GAP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_tuning = '0;
    logic [7:0]  req_phase = '0;
    logic        busy, dds_reset, dds_wclk, dds_data, dds_fqud;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dds_serial_loader #(
        .RST_HI_CYC (RST_HI), .WCLK_HI_CYC (W_HI), .WCLK_LO_CYC (W_LO),
        .FQ_HI_CYC (FQ_HI), .GAP_CYC (GAP), .PH_IN_W (8)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_tuning (req_tuning), .req_phase (req_phase), .busy (busy),
        .dds_reset (dds_reset), .dds_wclk (dds_wclk), .dds_data (dds_data),
        .dds_fqud (dds_fqud)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] frame_of(input logic [31:0] tw, input logic [7:0] ph);
        return {ph[4:0], 3'b000, tw};
    endfunction

    // port monitor
    logic [39:0] exp_frame = '0;
    logic [39:0] cap = '0;
    int  nbits = 0, w_hi = 0, w_lo = 0, f_hi = 0, d_run = 0, r_run = 0;
    int  boot_wclk = 0, boot_fq = 0, pre_busy = 0, fq_pulses = 0, late_reset = 0;
    bit  init_seen = 1'b0, p_wclk = 1'b0, p_fq = 1'b0, p_data = 1'b0, hold_bit = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_wclk = 1'b0; p_fq = 1'b0; p_data = dds_data; d_run = 1;
            w_hi = 0; w_lo = 0; f_hi = 0;
        end else begin
            if (dds_data == p_data) d_run++; else d_run = 1;
            if (dds_wclk && !p_wclk) begin
                if (init_seen) begin
                    chk(w_lo >= W_LO, "R5 wclk low before rise", w_lo, W_LO);
                    chk(d_run >= W_LO + 1, "R5 data setup", d_run, W_LO + 1);
                    cap = {dds_data, cap[39:1]};
                    nbits++;
                end else begin
                    boot_wclk++;
                end
                w_hi = 1; hold_bit = dds_data;
            end else if (dds_wclk) begin
                w_hi++;
                if (dds_data != hold_bit) chk(1'b0, "R5 data hold", dds_data, hold_bit);
            end else if (p_wclk) begin
                chk(w_hi == W_HI, "R5 wclk high width", w_hi, W_HI);
                w_lo = 1;
            end else begin
                w_lo++;
            end
            if (dds_fqud && !p_fq) begin
                if (init_seen) begin
                    chk(nbits == NBITS, "R3 bit count", nbits, NBITS);
                    chk(cap == exp_frame, "R3 frame", cap, exp_frame);
                    chk(cap[34:32] == 3'b000, "R4 control/power-down bits", cap[34:32], 0);
                    fq_pulses++;
                    nbits = 0;
                end else begin
                    boot_fq++;
                end
                f_hi = 1;
            end else if (dds_fqud) begin
                f_hi++;
            end else if (p_fq) begin
                chk(f_hi == FQ_HI, "R6 strobe width", f_hi, FQ_HI);
            end
            if (dds_wclk && dds_fqud) chk(1'b0, "R6 wclk and fqud together", 1, 0);
            if (dds_reset) begin
                if (init_seen) late_reset++; else r_run++;
            end
            if (!init_seen && busy) pre_busy++;
            if (req_ready && !init_seen) begin
                init_seen = 1'b1;
                chk(r_run == RST_HI, "R1 reset pulse width", r_run, RST_HI);
                chk(boot_wclk == 1, "R1 start-up wclk pulses", boot_wclk, 1);
                chk(boot_fq == 1, "R1 start-up fqud pulses", boot_fq, 1);
                chk(pre_busy == 0, "R9 busy during start-up", pre_busy, 0);
            end
            p_wclk = dds_wclk; p_fq = dds_fqud; p_data = dds_data;
        end
    end

    task automatic complete();
        int bcnt;
        fq_pulses = 0;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid  = 1'b0;
        req_tuning = ~req_tuning;
        req_phase  = ~req_phase;
        @(negedge clk);
        chk(busy && !req_ready, "R7 busy after accept", {busy, req_ready}, 2'b10);
        bcnt = 0;
        while (busy) begin
            bcnt++;
            @(negedge clk);
        end
        chk(bcnt == BUSY_CYC, "R7 busy length", bcnt, BUSY_CYC);
        chk(req_ready, "R2 ready after transfer", req_ready, 1);
        chk(fq_pulses == 1, "R6 strobe count", fq_pulses, 1);
        chk(nbits == 0, "R3 no stray bits", nbits, 0);
    endtask

    task automatic send(input logic [31:0] tw, input logic [7:0] ph);
        @(posedge clk); #1;
        req_valid  = 1'b1;
        req_tuning = tw;
        req_phase  = ph;
        exp_frame  = frame_of(tw, ph);
        complete();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dds_reset, "R1 reset pin during reset", dds_reset, 1);
        chk(!dds_wclk && !dds_fqud, "R1 pins low during reset", {dds_wclk, dds_fqud}, 0);
        chk(!req_ready && !busy, "R1 ready/busy during reset", {req_ready, busy}, 0);
        // R9: request already pending while start-up runs
        @(posedge clk); #1;
        req_valid  = 1'b1;
        req_tuning = 32'h1234_5678;
        req_phase  = 8'h2A;
        exp_frame  = frame_of(32'h1234_5678, 8'h2A);
        rst_n      = 1'b1;
        complete();
        chk(init_seen, "R9 start-up finished", init_seen, 1);
        // directed corners (R3, R4)
        send(32'h0000_0000, 8'h00);
        send(32'hFFFF_FFFF, 8'hFF);
        send(32'h8000_0001, 8'h1F);
        send(32'hA5A5_5A5A, 8'hE0);
        for (int i = 0; i < 16; i++) begin
            send($urandom, 8'($urandom));
        end
        repeat (5) @(negedge clk);
        chk(late_reset == 0, "R8 reset after start-up", late_reset, 0);
        chk(!dds_wclk && !dds_fqud, "R2 idle pins", {dds_wclk, dds_fqud}, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule